// File: doc/BRIEF.md
# IDE PIO Write Sequencer

This block runs one host-side programmed-I/O register write on a parallel disk interface. A one-cycle start request captures a 16-bit write value, a register address and a 3-bit transfer mode. The block then steps through four timed phases. It drives the address and write value, switches the data bus driver on and off, and pulses the write strobe. It reports busy while the cycle runs and gives a one-clock done pulse at the end.

All phase lengths are given in nanoseconds per mode as parameters. At elaboration they are converted to clock cycles by rounding up, with a floor of one cycle. If the sum of the phases falls short of the mode's minimum cycle time, the recovery phase is lengthened until the minimum is met. All these values are fixed before the first clock edge, so the sequencer holds only a phase counter and a few capture registers.

Top module: `pio_wr_seq`

## Requirements
- R1: While rst_ni is low, and in the first sampled cycle after it goes low (even in the middle of a write), busy_o, data_oe_o, wr_stb_o and done_o are all 0.
- R2: A start_i seen on a clock edge while busy_o is 0 is accepted. busy_o is 1 from the next cycle, and wdata_o and addr_o carry the values captured on that edge and hold them stable while busy_o is 1.
- R3: Setup phase. For the first S cycles after acceptance, busy_o=1 and data_oe_o=0 and wr_stb_o=0. S = ceil(setup_ns/CLK_PERIOD_NS), and setup_ns is 30, 20, 15, 10, 5 for modes 0 to 4.
- R4: Data phase. The next D cycles have data_oe_o=1 and wr_stb_o=0, and the bus is always driven before the strobe rises. D comes from 70, 50, 30, 30, 25 ns.
- R5: Strobe phase. The next W cycles have wr_stb_o=1 and data_oe_o=1. W comes from 290, 290, 290, 80, 70 ns.
- R6: Recovery phase. The next R cycles have busy_o=1, data_oe_o=0 and wr_stb_o=0, and data_oe_o falls in the same cycle as wr_stb_o. R comes from 240, 50, 20, 70, 25 ns.
- R7: In the cycle after recovery ends, done_o=1 for exactly one cycle and busy_o=0 in that cycle.
- R8: A start_i seen while busy_o is 1 has no effect. The running cycle, its captured data and its timing are unchanged, and no further cycle follows it.
- R9: The mode is captured at acceptance. A change of mode_i during a cycle does not change that cycle's phase lengths.
- R10: A mode_i value of 5, 6 or 7 gives mode 0 timing.
- R11: The number of busy cycles is max(S+D+W+R, ceil(min_ns/CLK_PERIOD_NS)), and any shortfall is added to recovery. min_ns defaults to 600, 383, 330, 180, 120 ns for modes 0 to 4 and can be overridden per mode.
- R12: Every phase lasts at least one cycle, and any ns-to-cycle conversion with a remainder rounds up.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request one write cycle |
| wdata_i | input | DATA_W (16) | Value to write |
| addr_i | input | ADDR_W (3) | Target register address |
| mode_i | input | 3 | Transfer mode, 0 to 4; values above 4 select mode 0 |
| addr_o | output | ADDR_W (3) | Captured address |
| wdata_o | output | DATA_W (16) | Captured write value |
| data_oe_o | output | 1 | Data bus driver enable |
| wr_stb_o | output | 1 | Write strobe, high during the strobe phase, low when idle |
| busy_o | output | 1 | Cycle in progress |
| done_o | output | 1 | One-clock pulse after a cycle completes |

## Verification
All outputs come straight from registers. A start driven before an edge therefore shows busy_o and the setup-phase levels in the very next cycle. Each later phase edge falls exactly S, S+D and S+D+W cycles after that, and done_o appears in cycle S+D+W+R'+1. The bench counts cycles from the accepting edge and samples on falling edges. At each sample it compares the output levels with the phase the tables put that cycle in. A second instance with raised minimum cycle times shows the recovery extension. Reset, disturbance and ignored starts are checked in the cycle after they are applied.

// File: rtl/pio_wr_pkg.sv
package pio_wr_pkg;

  localparam int unsigned NUM_MODES = 5;
  localparam int unsigned MODE_W    = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_DATA,
    ST_STRB,
    ST_REC
  } pio_st_e;

  // ns -> cycles, round up, never below one cycle
  function automatic int unsigned ns2cyc(int unsigned ns, int unsigned per);
    int unsigned r;
    r = (ns + per - 1) / per;
    if (r == 0) r = 1;
    return r;
  endfunction

endpackage

// File: rtl/pio_wr_lut.sv
module pio_wr_lut
  import pio_wr_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS = 4,
  parameter int unsigned CNT_W         = 10,
  parameter logic [NUM_MODES-1:0][15:0] SETUP_NS = {16'd5,  16'd10, 16'd15,  16'd20,  16'd30},
  parameter logic [NUM_MODES-1:0][15:0] DATA_NS  = {16'd25, 16'd30, 16'd30,  16'd50,  16'd70},
  parameter logic [NUM_MODES-1:0][15:0] STRB_NS  = {16'd70, 16'd80, 16'd290, 16'd290, 16'd290},
  parameter logic [NUM_MODES-1:0][15:0] REC_NS   = {16'd25, 16'd70, 16'd20,  16'd50,  16'd240},
  parameter logic [NUM_MODES-1:0][15:0] MIN_NS   = {16'd120,16'd180,16'd330, 16'd383, 16'd600}
) (
  input  logic [MODE_W-1:0] mode_i,
  output logic [CNT_W-1:0]  setup_len_o,
  output logic [CNT_W-1:0]  data_len_o,
  output logic [CNT_W-1:0]  strb_len_o,
  output logic [CNT_W-1:0]  rec_len_o
);

  localparam logic [MODE_W-1:0] MODE_MAX = MODE_W'(NUM_MODES - 1);

  logic [NUM_MODES-1:0][CNT_W-1:0] s_tab, d_tab, w_tab, r_tab;

  for (genvar m = 0; m < NUM_MODES; m++) begin : g_mode
    localparam int unsigned S_C   = ns2cyc(int'(SETUP_NS[m]), CLK_PERIOD_NS);
    localparam int unsigned D_C   = ns2cyc(int'(DATA_NS[m]),  CLK_PERIOD_NS);
    localparam int unsigned W_C   = ns2cyc(int'(STRB_NS[m]),  CLK_PERIOD_NS);
    localparam int unsigned R_C   = ns2cyc(int'(REC_NS[m]),   CLK_PERIOD_NS);
    localparam int unsigned M_C   = ns2cyc(int'(MIN_NS[m]),   CLK_PERIOD_NS);
    localparam int unsigned SUM_C = S_C + D_C + W_C + R_C;
    // shortfall against minimum cycle time goes into recovery
    localparam int unsigned RX_C  = (M_C > SUM_C) ? R_C + (M_C - SUM_C) : R_C;
    assign s_tab[m] = CNT_W'(S_C);
    assign d_tab[m] = CNT_W'(D_C);
    assign w_tab[m] = CNT_W'(W_C);
    assign r_tab[m] = CNT_W'(RX_C);
  end

  logic [MODE_W-1:0] idx;
  assign idx = (mode_i > MODE_MAX) ? '0 : mode_i;

  assign setup_len_o = s_tab[idx];
  assign data_len_o  = d_tab[idx];
  assign strb_len_o  = w_tab[idx];
  assign rec_len_o   = r_tab[idx];

endmodule

// File: rtl/pio_wr_cnt.sv
module pio_wr_cnt #(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= len_i - CNT_W'(1);
    else if (cnt_q != '0)   cnt_q <= cnt_q - CNT_W'(1);
  end

  assign zero_o = (cnt_q == '0);

  // a zero-length phase would underflow the counter
  p_len_min_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> (len_i != '0));

endmodule

// File: rtl/pio_wr_seq.sv
module pio_wr_seq
  import pio_wr_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS = 4,
  parameter int unsigned DATA_W        = 16,
  parameter int unsigned ADDR_W        = 3,
  parameter int unsigned CNT_W         = 10,
  parameter logic [NUM_MODES-1:0][15:0] SETUP_NS = {16'd5,  16'd10, 16'd15,  16'd20,  16'd30},
  parameter logic [NUM_MODES-1:0][15:0] DATA_NS  = {16'd25, 16'd30, 16'd30,  16'd50,  16'd70},
  parameter logic [NUM_MODES-1:0][15:0] STRB_NS  = {16'd70, 16'd80, 16'd290, 16'd290, 16'd290},
  parameter logic [NUM_MODES-1:0][15:0] REC_NS   = {16'd25, 16'd70, 16'd20,  16'd50,  16'd240},
  parameter logic [NUM_MODES-1:0][15:0] MIN_NS   = {16'd120,16'd180,16'd330, 16'd383, 16'd600}
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [MODE_W-1:0] mode_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              data_oe_o,
  output logic              wr_stb_o,
  output logic              busy_o,
  output logic              done_o
);

  localparam logic [MODE_W-1:0] MODE_MAX = MODE_W'(NUM_MODES - 1);

  pio_st_e           st_q, st_d;
  logic [MODE_W-1:0] mode_q, mode_in, lut_mode;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              done_q, done_d;
  logic              load, zero;
  logic [CNT_W-1:0]  len;
  logic [CNT_W-1:0]  s_len, d_len, w_len, r_len;
  logic              accept;

  assign mode_in  = (mode_i > MODE_MAX) ? '0 : mode_i;
  assign lut_mode = (st_q == ST_IDLE) ? mode_in : mode_q;
  assign accept   = (st_q == ST_IDLE) && start_i;

  pio_wr_lut #(
    .CLK_PERIOD_NS(CLK_PERIOD_NS),
    .CNT_W        (CNT_W),
    .SETUP_NS     (SETUP_NS),
    .DATA_NS      (DATA_NS),
    .STRB_NS      (STRB_NS),
    .REC_NS       (REC_NS),
    .MIN_NS       (MIN_NS)
  ) u_lut (
    .mode_i     (lut_mode),
    .setup_len_o(s_len),
    .data_len_o (d_len),
    .strb_len_o (w_len),
    .rec_len_o  (r_len)
  );

  pio_wr_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load),
    .len_i (len),
    .zero_o(zero)
  );

  always_comb begin
    st_d   = st_q;
    load   = 1'b0;
    len    = s_len;
    done_d = 1'b0;
    unique case (st_q)
      ST_IDLE:  if (start_i) begin st_d = ST_SETUP; load = 1'b1; len = s_len; end
      ST_SETUP: if (zero)    begin st_d = ST_DATA;  load = 1'b1; len = d_len; end
      ST_DATA:  if (zero)    begin st_d = ST_STRB;  load = 1'b1; len = w_len; end
      ST_STRB:  if (zero)    begin st_d = ST_REC;   load = 1'b1; len = r_len; end
      ST_REC:   if (zero)    begin st_d = ST_IDLE;  done_d = 1'b1;           end
      default:               st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
    end
  end

  // captured on acceptance only; busy starts are dropped
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else if (accept) begin
      mode_q <= mode_in;
      addr_q <= addr_i;
      data_q <= wdata_i;
    end
  end

  assign addr_o    = addr_q;
  assign wdata_o   = data_q;
  assign busy_o    = (st_q != ST_IDLE);
  assign data_oe_o = (st_q == ST_DATA) || (st_q == ST_STRB);
  assign wr_stb_o  = (st_q == ST_STRB);
  assign done_o    = done_q;

  p_accept_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> ($stable(wdata_o) && $stable(addr_o)));

  p_bus_first_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wr_stb_o) |-> $past(data_oe_o));

  p_stb_oe_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_o |-> data_oe_o);

  p_oe_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(data_oe_o) |-> $fell(wr_stb_o));

  p_done_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

endmodule

// File: tb/pio_wr_seq_test.sv
`timescale 1ns/1ps
module pio_wr_seq_test;

  localparam int unsigned P = 4;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] wdata_i = '0;
  logic [2:0]  addr_i = '0;
  logic [2:0]  mode_i = '0;

  logic [2:0]  addr_o, x_addr;
  logic [15:0] wdata_o, x_wdata;
  logic        data_oe_o, wr_stb_o, busy_o, done_o;
  logic        x_oe, x_stb, x_busy, x_done;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  pio_wr_seq #(.CLK_PERIOD_NS(P)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .wdata_i(wdata_i),
    .addr_i(addr_i), .mode_i(mode_i), .addr_o(addr_o), .wdata_o(wdata_o),
    .data_oe_o(data_oe_o), .wr_stb_o(wr_stb_o), .busy_o(busy_o), .done_o(done_o)
  );

  // raised minimum cycle times force recovery extension
  pio_wr_seq #(
    .CLK_PERIOD_NS(P),
    .MIN_NS({16'd400, 16'd500, 16'd600, 16'd700, 16'd800})
  ) uut_x (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .wdata_i(wdata_i),
    .addr_i(addr_i), .mode_i(mode_i), .addr_o(x_addr), .wdata_o(x_wdata),
    .data_oe_o(x_oe), .wr_stb_o(x_stb), .busy_o(x_busy), .done_o(x_done)
  );

  function automatic int cyc(int ns);
    int r = (ns + P - 1) / P;
    return (r < 1) ? 1 : r;
  endfunction
  function automatic int t_set(int m);
    case (m) 0: return 30; 1: return 20; 2: return 15; 3: return 10; default: return 5; endcase
  endfunction
  function automatic int t_dat(int m);
    case (m) 0: return 70; 1: return 50; 2: return 30; 3: return 30; default: return 25; endcase
  endfunction
  function automatic int t_stb(int m);
    case (m) 0: return 290; 1: return 290; 2: return 290; 3: return 80; default: return 70; endcase
  endfunction
  function automatic int t_rec(int m);
    case (m) 0: return 240; 1: return 50; 2: return 20; 3: return 70; default: return 25; endcase
  endfunction
  function automatic int t_min(int m);
    case (m) 0: return 600; 1: return 383; 2: return 330; 3: return 180; default: return 120; endcase
  endfunction
  function automatic int t_minx(int m);
    case (m) 0: return 800; 1: return 700; 2: return 600; 3: return 500; default: return 400; endcase
  endfunction
  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic run(int m, logic [15:0] d, logic [2:0] a, bit disturb);
    int em, s, dd, w, r, tot, xtot, k, xb, hold_err;
    int errs[5];
    int ga[5];
    int ea[5];
    bit main_done, xd;
    logic [3:0] ex, got;
    int ph;
    string tags[5] = '{"R3 setup", "R4 data", "R5 strobe", "R6 recovery", "R7 done"};
    em   = (m > 4) ? 0 : m;
    s    = cyc(t_set(em));
    dd   = cyc(t_dat(em));
    w    = cyc(t_stb(em));
    r    = imax(cyc(t_rec(em)), cyc(t_min(em)) - s - dd - w);
    tot  = s + dd + w + r;
    xtot = imax(s + dd + w + cyc(t_rec(em)), cyc(t_minx(em)));
    for (int i = 0; i < 5; i++) begin errs[i] = 0; ga[i] = 0; ea[i] = 0; end
    hold_err = 0; xb = 0; main_done = 0; xd = 0;
    @(negedge clk);
    mode_i = m[2:0]; wdata_i = d; addr_i = a; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (disturb) mode_i = 3'($urandom_range(0, 7));
    k = 1;
    while (!(main_done && xd) && k < 600) begin
      got = {busy_o, data_oe_o, wr_stb_o, done_o};
      if (k <= s)               begin ex = 4'b1000; ph = 0; end
      else if (k <= s + dd)     begin ex = 4'b1100; ph = 1; end
      else if (k <= s + dd + w) begin ex = 4'b1110; ph = 2; end
      else if (k <= tot)        begin ex = 4'b1000; ph = 3; end
      else                      begin ex = 4'b0001; ph = 4; end
      if (!main_done && got != ex) begin
        if (errs[ph] == 0) begin ga[ph] = int'(got); ea[ph] = int'(ex); end
        errs[ph]++;
      end
      if (k == tot + 1) main_done = 1;
      if (busy_o && (wdata_o != d || addr_o != a)) hold_err++;
      if (x_busy) xb++;
      if (x_done) xd = 1;
      start_i = disturb && (k == 3);
      if (disturb && k == 3) wdata_i = ~d;
      @(negedge clk);
      k++;
    end
    start_i = 1'b0;
    for (int i = 0; i < 5; i++)
      check(errs[i] == 0, tags[i], $sformatf("mode %0d {busy,oe,stb,done}", m), ga[i], ea[i]);
    check(hold_err == 0, "R2", "captured data/addr held while busy", hold_err, 0);
    check(xb == xtot, "R11", $sformatf("extended busy cycles mode %0d", m), xb, xtot);
    if (disturb) begin
      check(!busy_o && !x_busy, "R8", "start while busy ignored, no second cycle",
            int'(busy_o), 0);
      check(wdata_o == d, "R8", "captured data after ignored start", int'(wdata_o), int'(d));
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    check({busy_o, data_oe_o, wr_stb_o, done_o} == 4'b0, "R1", "outputs in reset",
          int'({busy_o, data_oe_o, wr_stb_o, done_o}), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check(!busy_o, "R1", "idle after reset release", int'(busy_o), 0);

    // R3-R7 and R12 per mode
    for (int m = 0; m < 5; m++) run(m, 16'hA500 + 16'(m), 3'(m), 1'b0);
    // R10: out-of-range modes
    run(5, 16'h1234, 3'd5, 1'b0);
    run(7, 16'hFFFF, 3'd7, 1'b0);
    // R8, R9: busy start and mode change mid-cycle
    run(4, 16'h0F0F, 3'd2, 1'b1);
    run(0, 16'hF0F0, 3'd6, 1'b1);

    // R1: reset mid-strobe
    @(negedge clk);
    mode_i = 3'd0; start_i = 1'b1; wdata_i = 16'h7777;
    @(negedge clk);
    start_i = 1'b0;
    repeat (40) @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    check({busy_o, data_oe_o, wr_stb_o, done_o} == 4'b0, "R1", "outputs after mid-cycle reset",
          int'({busy_o, data_oe_o, wr_stb_o, done_o}), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    check(!busy_o && !wr_stb_o, "R1", "stays idle after reset", int'(busy_o), 0);

    for (int i = 0; i < 25; i++)
      run(int'($urandom_range(0, 7)), 16'($urandom), 3'($urandom), bit'($urandom_range(0, 1)));

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule